// File: doc/BRIEF.md
# Maritime Selective-Calling Ten-Bit Character Codec

This block converts a 7-bit symbol value (0 to 127) into the 10-bit self-checking character used for maritime digital selective calling, and checks received characters. A character has seven information bits, carrying the value least-significant bit first, and then a three-bit check field. The check field holds the number of zero bits among the information bits, written most-significant bit first. Logic 0 corresponds to the B tone and logic 1 to the Y tone.

The transmit side accepts a value over a valid/ready handshake. `in_ready` is high only while the serializer is idle. A value is taken in any cycle where both `in_valid` and `in_ready` are high. While a character is being sent, `in_ready` stays low and `in_valid` has no effect. The source must hold `in_value` stable while it waits for `in_ready`. The accepted character appears in parallel on `tx_char`. It is also shifted out on `ser_out`, one bit for each `bit_en` pulse, with bit position 1 first. `done` pulses once after the tenth bit. The receive side is purely combinational. It returns the information field of `rx_char` and flags a mismatch between the recomputed zero count and the received check field.

Bit vectors in this block use index i for character position i+1. Index 0 is transmitted first.

Top module: `dsc_char_codec`

## Requirements
- R1: After an accept, `tx_char[6:0]` equals the accepted value, with value bit k at index k (position k+1). For example, value 1 sets only index 0 and value 8 sets only index 3.
- R2: The check field holds z, the number of zero bits in the value: `tx_char[7]`=z[2], `tx_char[8]`=z[1], `tx_char[9]`=z[0]. Value 0 gives 1,1,1 and value 127 gives 0,0,0.
- R3: `tx_char` updates in the cycle after an accept and then holds until the next accept.
- R4: While a character is being sent, `ser_out` shows index k after k `bit_en` pulses. Index 0 is shown from the cycle after the accept. Cycles without `bit_en` leave `ser_out` unchanged.
- R5: `in_ready` is high exactly when idle. An accept makes `in_ready` low from the next cycle. `in_valid` while not ready changes neither `tx_char` nor the serial stream.
- R6: `done` is high for exactly one cycle, the cycle after the tenth `bit_en` pulse. In that cycle `in_ready` is high again and `ser_out` is 1.
- R7: When idle, `ser_out` is 1 and `bit_en` has no effect: it does not change `ser_out` and does not raise `done`.
- R8: `rx_value` equals `rx_char[6:0]` for every 10-bit input, including inputs with a bad check field.
- R9: `rx_check_err` is 1 exactly when {`rx_char[7]`,`rx_char[8]`,`rx_char[9]`}, read as a binary number with `rx_char[7]` as MSB, differs from the count of zeros in `rx_char[6:0]`.
- R10: After reset, `ser_out`=1, `done`=0, `in_ready`=1 and `tx_char`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Value offered |
| in_ready | output | 1 | Serializer idle, value can be accepted |
| in_value | input | 7 | Symbol value to encode |
| bit_en | input | 1 | Advance serial output by one bit |
| ser_out | output | 1 | Serial character, position 1 first, 1 when idle |
| tx_char | output | 10 | Last accepted character, index i = position i+1 |
| done | output | 1 | One-cycle pulse after the tenth bit |
| rx_char | input | 10 | Received character, index i = position i+1 |
| rx_value | output | 7 | Decoded symbol value |
| rx_check_err | output | 1 | Check field does not match zero count |

## Verification
A wrong bit counter shows at the ports within one character time. `done` then comes early or late relative to the tenth `bit_en` pulse, and `in_ready` returns at the wrong moment. A corrupted shift register shows on `ser_out` at the first `bit_en` pulse after the fault. An encoder placement or counting fault shows on `tx_char` in the cycle after the accept. The bench sweeps all 128 values through both the parallel and serial paths, and all 1024 received patterns through the checker. It compares each result with a bit-by-bit count made in the bench.

// File: rtl/dsc_char_pkg.sv
package dsc_char_pkg;
  localparam int INFO_W = 7;
  localparam int CHK_W  = $clog2(INFO_W + 1);
  localparam int CHAR_W = INFO_W + CHK_W;
  localparam int CNT_W  = $clog2(CHAR_W);

  typedef logic [INFO_W-1:0] info_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [CHAR_W-1:0] char_t;

  function automatic chk_t zero_count(input info_t v);
    chk_t n;
    n = '0;
    for (int i = 0; i < INFO_W; i++) begin
      if (!v[i]) n = n + chk_t'(1);
    end
    return n;
  endfunction
endpackage

// File: rtl/dsc_char_enc.sv
module dsc_char_enc
  import dsc_char_pkg::*;
(
  input  info_t value,
  output char_t char_o
);
  chk_t zc;
  assign zc = zero_count(value);
  assign char_o[INFO_W-1:0] = value;

  // check field: count MSB lands at the first check position
  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    assign char_o[INFO_W+j] = zc[CHK_W-1-j];
  end
endmodule

// File: rtl/dsc_char_dec.sv
module dsc_char_dec
  import dsc_char_pkg::*;
(
  input  char_t rx_char,
  output info_t rx_value,
  output logic  rx_check_err
);
  chk_t rcv;
  for (genvar j = 0; j < CHK_W; j++) begin : g_rcv
    assign rcv[CHK_W-1-j] = rx_char[INFO_W+j];
  end

  assign rx_value     = rx_char[INFO_W-1:0];
  assign rx_check_err = (rcv != zero_count(rx_char[INFO_W-1:0]));
endmodule

// File: rtl/dsc_char_ser.sv
module dsc_char_ser
  import dsc_char_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  char_t load_char,
  input  logic  bit_en,
  output logic  busy,
  output logic  ser_out,
  output logic  done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

  char_t            shreg;
  logic [CNT_W-1:0] cnt;
  logic             busy_q, done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        shreg  <= load_char;
        cnt    <= '0;
        busy_q <= 1'b1;
      end else if (busy_q && bit_en) begin
        shreg <= shreg >> 1;
        if (cnt == LAST) begin
          cnt    <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign ser_out = busy_q ? shreg[0] : 1'b1;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && ser_out));
  // R4
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> $stable(ser_out));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> (!busy && !done && ser_out));
endmodule

// File: rtl/dsc_char_codec.sv
module dsc_char_codec
  import dsc_char_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INFO_W-1:0] in_value,
  input  logic              bit_en,
  output logic              ser_out,
  output logic [CHAR_W-1:0] tx_char,
  output logic              done,
  input  logic [CHAR_W-1:0] rx_char,
  output logic [INFO_W-1:0] rx_value,
  output logic              rx_check_err
);
  char_t enc_char;
  char_t tx_q;
  logic  busy, accept;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  dsc_char_enc u_enc (.value(in_value), .char_o(enc_char));

  always_ff @(posedge clk) begin
    if (!rst_n) tx_q <= '0;
    else if (accept) tx_q <= enc_char;
  end
  assign tx_char = tx_q;

  dsc_char_ser u_ser (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_char(enc_char),
    .bit_en(bit_en), .busy(busy), .ser_out(ser_out), .done(done)
  );

  dsc_char_dec u_dec (.rx_char(rx_char), .rx_value(rx_value),
                      .rx_check_err(rx_check_err));

  // R1
  info_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (tx_char[INFO_W-1:0] == $past(in_value)));
  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R3
  hold_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(tx_char));
endmodule

// File: tb/dsc_char_codec_bench.sv
module dsc_char_codec_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [6:0] in_value = '0;
  logic       bit_en = 1'b0;
  logic       ser_out;
  logic [9:0] tx_char;
  logic       done;
  logic [9:0] rx_char = '0;
  logic [6:0] rx_value;
  logic       rx_check_err;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dsc_char_codec u_dsc_char_codec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .bit_en(bit_en), .ser_out(ser_out),
    .tx_char(tx_char), .done(done), .rx_char(rx_char),
    .rx_value(rx_value), .rx_check_err(rx_check_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] expect_char(input int v);
    logic [9:0] c;
    int z;
    z = 0;
    for (int i = 0; i < 7; i++) begin
      c[i] = ((v >> i) & 1) != 0;
      if (((v >> i) & 1) == 0) z++;
    end
    c[7] = ((z >> 2) & 1) != 0;
    c[8] = ((z >> 1) & 1) != 0;
    c[9] = (z & 1) != 0;
    return c;
  endfunction

  task automatic send(input int v, input bit gaps);
    logic [9:0] e;
    e = expect_char(v);
    in_value = 7'(v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tx_char == e, "R1/R2/R3 tx_char", int'(tx_char), int'(e));
    check(in_ready == 1'b0, "R5 busy after accept", int'(in_ready), 0);
    for (int k = 0; k < 10; k++) begin
      check(ser_out == e[k], "R4 serial bit", int'(ser_out), int'(e[k]));
      check(done == 1'b0, "R6 done early", int'(done), 0);
      if (gaps) begin
        // R5: offer a different value while busy
        in_valid = 1'b1;
        in_value = 7'(v ^ 7'h55);
        @(negedge clk);
        in_valid = 1'b0;
        check(ser_out == e[k], "R4 hold without bit_en", int'(ser_out), int'(e[k]));
        check(tx_char == e, "R5 ignored while busy", int'(tx_char), int'(e));
      end
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
    end
    check(done == 1'b1, "R6 done pulse", int'(done), 1);
    check(in_ready == 1'b1, "R6 ready at done", int'(in_ready), 1);
    check(ser_out == 1'b1, "R6 mark at done", int'(ser_out), 1);
    @(negedge clk);
    check(done == 1'b0, "R6 single pulse", int'(done), 0);
    check(tx_char == e, "R3 tx_char held", int'(tx_char), int'(e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ser_out == 1'b1, "R10 ser_out", int'(ser_out), 1);
    check(done == 1'b0, "R10 done", int'(done), 0);
    check(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
    check(tx_char == 10'd0, "R10 tx_char", int'(tx_char), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: bit_en while idle
    for (int k = 0; k < 3; k++) begin
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      check(ser_out == 1'b1 && done == 1'b0, "R7 idle bit_en",
            int'({ser_out, done}), 2);
    end
    // R2 corner cases
    send(0, 1'b1);
    check(tx_char[9:7] == 3'b111, "R2 value 0 check", int'(tx_char[9:7]), 7);
    send(127, 1'b1);
    check(tx_char[9:7] == 3'b000, "R2 value 127 check", int'(tx_char[9:7]), 0);
    send(1, 1'b0);
    check(tx_char == 10'b0110000001, "R1 value 1", int'(tx_char), 10'b0110000001);
    send(8, 1'b0);
    check(tx_char[6:0] == 7'b0001000, "R1 value 8", int'(tx_char[6:0]), 8);
    for (int v = 0; v < 128; v++) send(v, v[3]);
    // R8, R9: every received pattern
    for (int c = 0; c < 1024; c++) begin
      int z;
      int rc;
      rx_char = 10'(c);
      #1;
      z = 0;
      for (int i = 0; i < 7; i++) if (((c >> i) & 1) == 0) z++;
      rc = (((c >> 7) & 1) << 2) | (((c >> 8) & 1) << 1) | ((c >> 9) & 1);
      check(int'(rx_value) == (c & 127), "R8 rx_value", int'(rx_value), c & 127);
      check(rx_check_err == (rc != z), "R9 rx_check_err",
            int'(rx_check_err), int'(rc != z));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule